// File: doc/BRIEF.md
# Clock Lock-Status Tracker

This block tracks whether a delay-locked clock stage may be trusted. It does not model the delay line or the phase detector. A free-running sampling clock, faster than the monitored input clock, samples that input clock as data through a synchronizer. It measures every period between rising edges in sampling cycles. It counts consecutive periods that meet the minimum-frequency limit. Once enough of them have arrived, it reports the stage as locked.

A period that is too long restarts the count. So does a gap with no edge at all that lasts past the stall threshold. Relocking needs no command: counting simply starts again once good periods return. A loop-enable pin, when driven low, parks the block in a bypass state in which clock activity is ignored. Dependent logic watches `locked`, `bypass` and the encoded state. It may also use the one-cycle `lost_lock` pulse to flush anything timed by the stage.

The thresholds are parameters derived from the sampling frequency:

- Maximum good period: ceil(`SAMPLE_MHZ`/`MIN_REF_MHZ`) sampling cycles, which is 17 by default.
- Stall threshold: ceil(`STALL_NS`·`SAMPLE_MHZ`/1000) sampling cycles, which is 60 by default.

The stall threshold must be larger than the maximum good period.

Top module: `clk_lock_tracker`

## Requirements
- R1: While reset is asserted, `lock_state` is 0 (DISABLED), `locked` and `lost_lock` are 0 and `bypass` is 1.
- R2: `lock_state` encodes 0 = DISABLED, 1 = ACQUIRING, 2 = LOCKED, 3 = STALLED. `locked` is high exactly in LOCKED and `bypass` is high exactly in DISABLED.
- R3: The first rising edge after reset, after a stall or after a slow period is only a reference. LOCKED is entered on the `LOCK_EDGES`-th (default 1024) consecutive good period after it, and not on the one before.
- R4: A period of at most the maximum good period (17 sampling cycles by default) is good. A longer period clears the count and, in LOCKED, returns the block to ACQUIRING.
- R5: An input clock whose every period is longer than the maximum never reaches LOCKED.
- R6: When no rising edge arrives for the stall threshold (60 sampling cycles by default), the block enters STALLED from ACQUIRING or LOCKED.
- R7: From STALLED, the next rising edge returns the block to ACQUIRING. LOCKED follows again after `LOCK_EDGES` good periods with no other action.
- R8: With `loop_en` low, the block enters DISABLED within three sampling cycles. It stays there regardless of input-clock edges or stalls.
- R9: When `loop_en` returns high, the block leaves DISABLED with its count at zero and must again collect `LOCK_EDGES` good periods.
- R10: `lost_lock` is a single-cycle pulse raised in the cycle `locked` falls, on every exit from LOCKED (slow period, stall or disable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk | input | 1 | Monitored input clock, sampled as data |
| loop_en | input | 1 | Loop enable; low selects bypass |
| locked | output | 1 | Lock achieved |
| bypass | output | 1 | Loop disabled |
| lost_lock | output | 1 | One-cycle pulse on leaving LOCKED |
| lock_state | output | 2 | Encoded tracker state |

## Verification
A wrong period count shows up as `locked` rising one good period early or late. The bench samples both sides of the `LOCK_EDGES` boundary, a few sampling cycles after the deciding edge, to catch this. A misjudged period length shows at the 17/18-cycle boundary as LOCKED being kept or lost within three sampling cycles of the edge. A missing or doubled `lost_lock` pulse shows in the running pulse tally that the bench compares at every check. A state that ignores `loop_en` or fails to leave STALLED is visible on `lock_state` within a few sampling cycles.

// File: rtl/clk_lock_pkg.sv
`timescale 1ns/1ps
package clk_lock_pkg;

  typedef enum logic [1:0] {
    ST_DISABLED  = 2'd0,
    ST_ACQUIRING = 2'd1,
    ST_LOCKED    = 2'd2,
    ST_STALLED   = 2'd3
  } lock_st_e;

  function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/lt_rst_sync.sv
`timescale 1ns/1ps
module lt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/lt_sync2.sv
`timescale 1ns/1ps
module lt_sync2 #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lt_gap_meter.sv
`timescale 1ns/1ps
module lt_gap_meter #(
  parameter int unsigned MAX_PERIOD = 17,
  parameter int unsigned STALL_CYC  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_s,
  output logic good_edge,
  output logic slow_edge,
  output logic stall
);
  localparam int unsigned CW = $clog2(STALL_CYC + 1);

  logic          ref_q;
  logic          rise;
  logic [CW-1:0] gap_q, gap_d;
  logic          seen_q, seen_d;
  logic          gap_we;

  assign rise  = ref_s & ~ref_q;
  assign stall = (gap_q == CW'(STALL_CYC));

  always_comb begin
    gap_d  = gap_q;
    seen_d = seen_q;
    gap_we = 1'b0;
    if (rise) begin
      gap_d  = '0;
      seen_d = 1'b1;
      gap_we = 1'b1;
    end else if (!stall) begin
      gap_d  = gap_q + 1'b1;
      gap_we = 1'b1;
    end else begin
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      ref_q  <= ref_s;
      seen_q <= seen_d;
      if (gap_we) gap_q <= gap_d;
    end
  end

  // A period of gap_q+1 sampling cycles ends at this edge
  assign good_edge = rise & seen_q & (gap_q <  CW'(MAX_PERIOD));
  assign slow_edge = rise & seen_q & (gap_q >= CW'(MAX_PERIOD));

  assert_gap_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= CW'(STALL_CYC));

  assert_stall_forgets_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rise) |=> !good_edge && !slow_edge);
endmodule

// File: rtl/lt_lock_fsm.sv
`timescale 1ns/1ps
module lt_lock_fsm
  import clk_lock_pkg::*;
#(
  parameter int unsigned LOCK_EDGES = 1024
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     good_edge,
  input  logic     slow_edge,
  input  logic     stall,
  output lock_st_e state_o,
  output logic     lost_o
);
  localparam int unsigned LW = $clog2(LOCK_EDGES + 1);
  localparam logic [LW-1:0] LAST = LW'(LOCK_EDGES - 1);

  lock_st_e      state_q, state_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          cnt_we;
  logic          lost_q, lost_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    cnt_we  = 1'b1;
    if (!en) begin
      state_d = ST_DISABLED;
    end else begin
      unique case (state_q)
        ST_DISABLED:  state_d = ST_ACQUIRING;
        ST_ACQUIRING: begin
          if (stall) begin
            state_d = ST_STALLED;
          end else if (good_edge) begin
            if (cnt_q == LAST) state_d = ST_LOCKED;
            else               cnt_d   = cnt_q + 1'b1;
          end else if (!slow_edge) begin
            cnt_we = 1'b0;
          end
        end
        ST_LOCKED: begin
          if (stall)          state_d = ST_STALLED;
          else if (slow_edge) state_d = ST_ACQUIRING;
        end
        ST_STALLED: begin
          if (!stall) state_d = ST_ACQUIRING;
        end
        default: state_d = ST_DISABLED;
      endcase
    end
    lost_d = (state_q == ST_LOCKED) && (state_d != ST_LOCKED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DISABLED;
      cnt_q   <= '0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lost_q  <= lost_d;
      if (cnt_we) cnt_q <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign lost_o  = lost_q;

  assert_lock_on_last_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_LOCKED) |-> ($past(cnt_q) == LAST) && $past(good_edge));

  assert_slow_drops_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slow_edge && !stall && state_q == ST_LOCKED) |=> state_q == ST_ACQUIRING);

  assert_stall_enters_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stall && (state_q == ST_ACQUIRING || state_q == ST_LOCKED)) |=> state_q == ST_STALLED);

  assert_disable_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == ST_DISABLED);

  assert_lost_marks_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |-> ($past(state_q) == ST_LOCKED) && (state_q != ST_LOCKED));
endmodule

// File: rtl/clk_lock_tracker.sv
`timescale 1ns/1ps
module clk_lock_tracker
  import clk_lock_pkg::*;
#(
  parameter int unsigned SAMPLE_MHZ  = 2000,
  parameter int unsigned MIN_REF_MHZ = 120,
  parameter int unsigned STALL_NS    = 30,
  parameter int unsigned LOCK_EDGES  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk,
  input  logic       loop_en,
  output logic       locked,
  output logic       bypass,
  output logic       lost_lock,
  output logic [1:0] lock_state
);
  localparam int unsigned MAX_PERIOD_CYC = div_ceil(SAMPLE_MHZ, MIN_REF_MHZ);
  localparam int unsigned STALL_CYC      = div_ceil(STALL_NS * SAMPLE_MHZ, 1000);

  logic     srst_n;
  logic     ref_s, en_s;
  logic     good_edge, slow_edge, stall;
  lock_st_e state;

  lt_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  lt_sync2 #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     ({ref_clk, loop_en}),
    .q     ({ref_s, en_s})
  );

  lt_gap_meter #(.MAX_PERIOD(MAX_PERIOD_CYC), .STALL_CYC(STALL_CYC)) u_gap (
    .clk       (clk),
    .rst_n     (srst_n),
    .ref_s     (ref_s),
    .good_edge (good_edge),
    .slow_edge (slow_edge),
    .stall     (stall)
  );

  lt_lock_fsm #(.LOCK_EDGES(LOCK_EDGES)) u_fsm (
    .clk       (clk),
    .rst_n     (srst_n),
    .en        (en_s),
    .good_edge (good_edge),
    .slow_edge (slow_edge),
    .stall     (stall),
    .state_o   (state),
    .lost_o    (lost_lock)
  );

  assign lock_state = state;
  assign locked     = (state == ST_LOCKED);
  assign bypass     = (state == ST_DISABLED);

  assert_lost_single_cycle_R10: assert property (@(posedge clk) disable iff (!srst_n)
    lost_lock |=> !lost_lock);

  assert_reset_state_R1: assert property (@(posedge clk)
    !srst_n |-> bypass && !locked && !lost_lock);
endmodule

// File: tb/sim_clk_lock_tracker.sv
`timescale 1ns/1ps
module sim_clk_lock_tracker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_clk;
  logic       loop_en;
  logic       locked, bypass, lost_lock;
  logic [1:0] lock_state;

  localparam logic [1:0] S_DIS = 2'd0, S_ACQ = 2'd1, S_LCK = 2'd2, S_STL = 2'd3;

  typedef struct {
    string      req;
    logic [1:0] st;
    int         lost;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   lost_seen = 0;
  logic lost_prev = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  clk_lock_tracker u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_clk    (ref_clk),
    .loop_en    (loop_en),
    .locked     (locked),
    .bypass     (bypass),
    .lost_lock  (lost_lock),
    .lock_state (lock_state)
  );

  // Monitor: tallies lost_lock pulses and compares queued expectations
  always @(negedge clk) begin
    if (lost_lock) begin
      lost_seen++;
      checks++;
      if (lost_prev) begin
        fails++;
        $display("FAIL R10 lost_lock width: actual 2+ cycles expected 1");
      end
    end
    lost_prev = lost_lock;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (lock_state !== e.st || locked !== (e.st == S_LCK) || bypass !== (e.st == S_DIS)
          || lost_seen != e.lost) begin
        fails++;
        $display("FAIL %s: actual state=%0d locked=%b bypass=%b lost=%0d expected state=%0d lost=%0d",
                 e.req, lock_state, locked, bypass, lost_seen, e.st, e.lost);
      end
    end
  end

  task automatic expect_st(input string r, input logic [1:0] st, input int lost);
    exp_t e;
    #1;
    e.req = r; e.st = st; e.lost = lost;
    q.push_back(e);
  endtask

  // n rising edges, each preceded by a period of 'gap' sampling cycles
  task automatic edges(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      ref_clk = 1'b0;
      repeat (gap - 4) @(negedge clk);
      ref_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic hold_low(input int n);
    ref_clk = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n   = 1'b0;
    ref_clk = 1'b0;
    loop_en = 1'b1;
    repeat (3) @(negedge clk);
    expect_st("R1 reset", S_DIS, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Initial lock: reference edge, then LOCK_EDGES good periods
    edges(1, 8);
    expect_st("R2 acquiring after reference", S_ACQ, 0);
    edges(1023, 8);
    expect_st("R3 not locked after 1023 periods", S_ACQ, 0);
    edges(1, 8);
    expect_st("R3 locked after 1024 periods", S_LCK, 0);

    // Slow clock
    edges(1, 24);
    expect_st("R4 slow period drops lock", S_ACQ, 1);
    edges(40, 24);
    expect_st("R5 slow clock never locks", S_ACQ, 1);
    edges(1023, 8);
    expect_st("R3 relock not early", S_ACQ, 1);
    edges(1, 8);
    expect_st("R3 relock after slow reference", S_LCK, 1);

    // Period limit boundary
    edges(5, 17);
    expect_st("R4 period 17 still good", S_LCK, 1);
    edges(1, 18);
    expect_st("R4 period 18 is slow", S_ACQ, 2);
    edges(1023, 8);
    expect_st("R4 count cleared by slow period", S_ACQ, 2);
    edges(1, 8);
    expect_st("R3 locked again", S_LCK, 2);

    // Stall and automatic recovery
    hold_low(100);
    expect_st("R6 stall detected", S_STL, 3);
    edges(1, 8);
    expect_st("R7 edge leaves stalled", S_ACQ, 3);
    edges(1023, 8);
    expect_st("R7 not yet relocked", S_ACQ, 3);
    edges(1, 8);
    expect_st("R7 automatic relock", S_LCK, 3);

    // Disable pin
    loop_en = 1'b0;
    repeat (5) @(negedge clk);
    expect_st("R8 disable enters bypass", S_DIS, 4);
    edges(1100, 8);
    expect_st("R8 edges ignored while disabled", S_DIS, 4);
    hold_low(100);
    expect_st("R8 stall ignored while disabled", S_DIS, 4);
    @(negedge clk);
    loop_en = 1'b1;
    repeat (6) @(negedge clk);
    expect_st("R9 enable leaves bypass into stalled", S_STL, 4);
    edges(1, 8);
    expect_st("R9 acquiring after reference", S_ACQ, 4);
    edges(1023, 8);
    expect_st("R9 count restarted from zero", S_ACQ, 4);
    edges(1, 8);
    expect_st("R9 locked after re-enable", S_LCK, 4);

    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule